// File: doc/BRIEF.md
# Bus Wait-State Alignment Unit

This block keeps a CPU cycle count and works out the extra wait cycles an access needs to line up with two slower timing grids. The first grid is a peripheral clock that runs at one tenth of the CPU rate. The second is a four-cycle bus slot that some display registers require. Every clock, the unit is told how many cycles the CPU has executed. It is also given strobes that ask for peripheral-clock sync, read-slot sync and write-slot sync, together with a mode bit and an end-of-instruction strobe.

In precise mode, each delay is added to the cycle count in the same clock that requests it. In deferred mode, the delays are summed into a per-instruction total. That total is released into the count on the end-of-instruction strobe, and the total then returns to zero. The position of the count within the ten-cycle grid is held in a small wrapping counter, so the count itself is never divided by ten.

Top module: `wait_align_unit`

## Requirements
- R1: A synchronous active-high reset sets the cycle count, the ten-cycle phase, the accumulator, the released total and all delay outputs to 0.
- R2: One clock after `e_sync_req`, `e_dly` holds the peripheral-clock delay: 0 if the count is a multiple of 10, otherwise 10 minus (count mod 10). The count used is the one before that clock. In a clock with no request, `e_dly` is 0 one clock later.
- R3: One clock after `rd_slot_req`, `rd_dly` holds 0 if (count mod 4) is 0, otherwise 4 minus (count mod 4). It is 0 when there is no request.
- R4: `wr_dly` uses the same rule as R3, applied to the count at the write access. When a read is requested in the same clock, that count is the current count plus the read delay, so a read-modify-write pays slot alignment only once.
- R5: Every clock, the cycle count advances by `cyc_step` plus any waits applied in that clock. In precise mode, the sum of that clock's delays is applied at once.
- R6: In deferred mode, every delay of a clock is added to `wait_acc`, including an E delay and slot delays requested in the same clock. In precise mode without `instr_end`, `wait_acc` holds its value.
- R7: On `instr_end`, `wait_rel` becomes the accumulator plus that clock's deferred delays. That amount is also added to the count, and `wait_acc` returns to 0.
- R8: The accumulator saturates at its all-ones value and never wraps.
- R9: When only even steps are taken from reset, `e_dly` only takes the values 0, 2, 4, 6 and 8.
- R10: `wait_rel` is 0 after every clock without `instr_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_step | input | STEP_W | CPU cycles executed this clock |
| e_sync_req | input | 1 | Request alignment to the ten-cycle peripheral clock |
| rd_slot_req | input | 1 | Request four-cycle slot alignment for a read |
| wr_slot_req | input | 1 | Request four-cycle slot alignment for a write |
| precise | input | 1 | 1: apply waits at once; 0: accumulate per instruction |
| instr_end | input | 1 | Instruction finishes this clock; release the accumulated waits |
| e_dly | output | 4 | Peripheral-clock delay from the previous clock |
| rd_dly | output | 2 | Read-slot delay from the previous clock |
| wr_dly | output | 2 | Write-slot delay from the previous clock |
| wait_acc | output | ACC_W | Accumulated deferred waits |
| wait_rel | output | ACC_W | Waits released by the previous `instr_end` |
| cyc_cnt | output | CNT_W | CPU cycle count including applied waits |

## Verification
The stimulus table varies the step size, which requests are active, the mode and the end-of-instruction strobe. This drives the count through every residue mod 10 and mod 4, so each branch of the delay rules is reached. A read and a write in the same clock separate the chained write position from a write that is aligned on its own. Switching modes in the middle of an instruction separates immediate application from deferred release. A long deferred run with no instruction end exposes a wrapping accumulator, and an even-step-only run confirms the restricted set of peripheral delays.

// File: rtl/wait_align_pkg.sv
package wait_align_pkg;
  localparam int E_DIV   = 10;
  localparam int E_W     = 4;
  localparam int SLOT_W  = 2;
  localparam int DSUM_W  = 5;

  typedef struct packed {
    logic [E_W-1:0]    e;
    logic [SLOT_W-1:0] rd;
    logic [SLOT_W-1:0] wr;
  } delay_set_t;

  // distance to the next four-cycle boundary
  function automatic logic [SLOT_W-1:0] slot_gap(input logic [SLOT_W-1:0] pos);
    return SLOT_W'(~pos + 1'b1);
  endfunction
endpackage

// File: rtl/e_phase_track.sv
module e_phase_track
  import wait_align_pkg::*;
#(
  parameter int ADV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ADV_W-1:0] adv,
  output logic [E_W-1:0]   gap
);
  localparam int RW = ADV_W + 4;

  logic [E_W-1:0] phase;
  logic [ADV_W-1:0] rem;
  logic [E_W:0] sum;
  logic [E_W-1:0] phase_nx;

  // reduce the advance modulo ten by restoring subtraction
  always_comb begin
    rem = adv;
    for (int i = ADV_W - 4; i >= 0; i--) begin
      if (RW'(rem) >= (RW'(E_DIV) << i))
        rem = rem - ADV_W'(RW'(E_DIV) << i);
    end
    sum = {1'b0, phase} + rem[E_W:0];
    if (sum >= (E_W+1)'(E_DIV))
      phase_nx = E_W'(sum - (E_W+1)'(E_DIV));
    else
      phase_nx = sum[E_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= phase_nx;
  end

  assign gap = (phase == '0) ? '0 : E_W'(E_DIV) - phase;
endmodule

// File: rtl/slot_align.sv
module slot_align
  import wait_align_pkg::*;
(
  input  logic [SLOT_W-1:0] cnt_lo,
  input  logic              rd_req,
  input  logic              wr_req,
  output logic [SLOT_W-1:0] rd_gap,
  output logic [SLOT_W-1:0] wr_gap
);
  logic [SLOT_W-1:0] wr_pos;

  always_comb begin
    rd_gap = rd_req ? slot_gap(cnt_lo) : '0;
    wr_pos = cnt_lo + rd_gap;
    wr_gap = wr_req ? slot_gap(wr_pos) : '0;
  end
endmodule

// File: rtl/wait_accum.sv
module wait_accum
  import wait_align_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DSUM_W-1:0] dsum,
  input  logic              precise,
  input  logic              instr_end,
  output logic [ACC_W-1:0]  rel_now,
  output logic [ACC_W-1:0]  acc_q,
  output logic [ACC_W-1:0]  rel_q
);
  logic [ACC_W:0]   pend;
  logic [ACC_W-1:0] pend_sat;

  always_comb begin
    pend     = {1'b0, acc_q} + (precise ? '0 : (ACC_W+1)'(dsum));
    pend_sat = pend[ACC_W] ? '1 : pend[ACC_W-1:0];
    rel_now  = instr_end ? pend_sat : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      rel_q <= '0;
    end else begin
      acc_q <= instr_end ? '0 : pend_sat;
      rel_q <= rel_now;
    end
  end
endmodule

// File: rtl/wait_align_unit.sv
module wait_align_unit
  import wait_align_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 4,
  parameter int ACC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] cyc_step,
  input  logic              e_sync_req,
  input  logic              rd_slot_req,
  input  logic              wr_slot_req,
  input  logic              precise,
  input  logic              instr_end,
  output logic [3:0]        e_dly,
  output logic [1:0]        rd_dly,
  output logic [1:0]        wr_dly,
  output logic [ACC_W-1:0]  wait_acc,
  output logic [ACC_W-1:0]  wait_rel,
  output logic [CNT_W-1:0]  cyc_cnt
);
  localparam int WIDE  = (ACC_W > STEP_W) ? ACC_W : STEP_W;
  localparam int ADV_W = WIDE + 2;

  logic [E_W-1:0]    e_gap;
  delay_set_t        now_d;
  logic [DSUM_W-1:0] dsum;
  logic [ACC_W-1:0]  rel_now;
  logic [ADV_W-1:0]  adv;

  e_phase_track #(.ADV_W(ADV_W)) u_phase (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .gap (e_gap)
  );

  slot_align u_slot (
    .cnt_lo (cyc_cnt[1:0]),
    .rd_req (rd_slot_req),
    .wr_req (wr_slot_req),
    .rd_gap (now_d.rd),
    .wr_gap (now_d.wr)
  );

  wait_accum #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .dsum      (dsum),
    .precise   (precise),
    .instr_end (instr_end),
    .rel_now   (rel_now),
    .acc_q     (wait_acc),
    .rel_q     (wait_rel)
  );

  always_comb begin
    now_d.e = e_sync_req ? e_gap : '0;
    dsum    = DSUM_W'(now_d.e) + DSUM_W'(now_d.rd) + DSUM_W'(now_d.wr);
    adv     = ADV_W'(cyc_step) + (precise ? ADV_W'(dsum) : '0) + ADV_W'(rel_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt <= '0;
      e_dly   <= '0;
      rd_dly  <= '0;
      wr_dly  <= '0;
    end else begin
      cyc_cnt <= cyc_cnt + CNT_W'(adv);
      e_dly   <= now_d.e;
      rd_dly  <= now_d.rd;
      wr_dly  <= now_d.wr;
    end
  end
endmodule

// File: rtl/wait_align_chk.sv
module wait_align_chk #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 4,
  parameter int ACC_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] cyc_step,
  input logic              e_sync_req,
  input logic              rd_slot_req,
  input logic              wr_slot_req,
  input logic              precise,
  input logic              instr_end,
  input logic [3:0]        e_dly,
  input logic [ACC_W-1:0]  wait_acc,
  input logic [ACC_W-1:0]  wait_rel,
  input logic [CNT_W-1:0]  cyc_cnt
);
  logic live = 1'b0;
  logic rst_q = 1'b0;
  always_ff @(posedge clk) begin
    live  <= !rst;
    rst_q <= rst;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (cyc_cnt == '0 && wait_acc == '0 && wait_rel == '0 && e_dly == '0)); // R1
  AST_E_RANGE: assert property (@(posedge clk) disable iff (rst || !live)
    e_dly <= 4'd9); // R2
  AST_E_IDLE: assert property (@(posedge clk) disable iff (rst || !live)
    !$past(e_sync_req) |-> e_dly == 4'd0); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || !live)
    $past(!instr_end && !e_sync_req && !rd_slot_req && !wr_slot_req)
      |-> cyc_cnt == $past(cyc_cnt) + CNT_W'($past(cyc_step))); // R5
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst || !live)
    $past(precise && !instr_end) |-> wait_acc == $past(wait_acc)); // R6
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst || !live)
    $past(instr_end) |-> wait_acc == '0); // R7
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst || !live)
    $past(!instr_end) |-> wait_acc >= $past(wait_acc)); // R8
  AST_REL_IDLE: assert property (@(posedge clk) disable iff (rst || !live)
    !$past(instr_end) |-> wait_rel == '0); // R10
endmodule

bind wait_align_unit wait_align_chk #(
  .CNT_W(CNT_W), .STEP_W(STEP_W), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .cyc_step(cyc_step), .e_sync_req(e_sync_req),
  .rd_slot_req(rd_slot_req), .wr_slot_req(wr_slot_req), .precise(precise),
  .instr_end(instr_end), .e_dly(e_dly), .wait_acc(wait_acc),
  .wait_rel(wait_rel), .cyc_cnt(cyc_cnt)
);

// File: tb/tb_wait_align_unit.sv
`timescale 1ns/1ps
module tb_wait_align_unit;
  localparam int CNT_W = 32, STEP_W = 4, ACC_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [STEP_W-1:0] cyc_step = '0;
  logic e_sync_req = 0, rd_slot_req = 0, wr_slot_req = 0, precise = 0, instr_end = 0;
  logic [3:0] e_dly;
  logic [1:0] rd_dly, wr_dly;
  logic [ACC_W-1:0] wait_acc, wait_rel;
  logic [CNT_W-1:0] cyc_cnt;

  always #2.5 clk = ~clk;

  wait_align_unit #(.CNT_W(CNT_W), .STEP_W(STEP_W), .ACC_W(ACC_W)) dut (
    .clk(clk), .rst(rst), .cyc_step(cyc_step), .e_sync_req(e_sync_req),
    .rd_slot_req(rd_slot_req), .wr_slot_req(wr_slot_req), .precise(precise),
    .instr_end(instr_end), .e_dly(e_dly), .rd_dly(rd_dly), .wr_dly(wr_dly),
    .wait_acc(wait_acc), .wait_rel(wait_rel), .cyc_cnt(cyc_cnt)
  );

  int n_chk = 0, n_bad = 0;
  longint m_cnt = 0, m_acc = 0;

  // {step[3:0], e, rd, wr, precise, instr_end}
  localparam logic [8:0] VEC [0:17] = '{
    {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {4'd6, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd15,1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drives one clock and compares against the requirement model
  task automatic cycle(input logic [8:0] v);
    longint e, r, w, wp, d, pend, rel, adv;
    @(negedge clk);
    {cyc_step, e_sync_req, rd_slot_req, wr_slot_req, precise, instr_end} = v;
    e  = !v[4] ? 0 : ((m_cnt % 10 == 0) ? 0 : 10 - m_cnt % 10);
    r  = !v[3] ? 0 : ((m_cnt % 4 == 0) ? 0 : 4 - m_cnt % 4);
    wp = m_cnt + r;
    w  = !v[2] ? 0 : ((wp % 4 == 0) ? 0 : 4 - wp % 4);
    d  = e + r + w;
    pend = m_acc + (v[1] ? 0 : d);
    if (pend > 255) pend = 255;
    adv = longint'(v[8:5]) + (v[1] ? d : 0);
    if (v[0]) begin rel = pend; m_acc = 0; adv += pend; end
    else begin rel = 0; m_acc = pend; end
    m_cnt = (m_cnt + adv) & 64'hFFFF_FFFF;
    @(posedge clk); #1;
    check("R2 e_dly", e_dly, e);
    check("R3 rd_dly", rd_dly, r);
    check("R4 wr_dly", wr_dly, w);
    check("R5 cyc_cnt", cyc_cnt, m_cnt);
    check("R6 wait_acc", wait_acc, m_acc);
    check(v[0] ? "R7 wait_rel" : "R10 wait_rel", wait_rel, rel);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; {cyc_step, e_sync_req, rd_slot_req, wr_slot_req, precise, instr_end} = '0;
    @(posedge clk); @(posedge clk); #1;
    m_cnt = 0; m_acc = 0;
    check("R1 cyc_cnt", cyc_cnt, 0);
    check("R1 wait_acc", wait_acc, 0);
    check("R1 wait_rel", wait_rel, 0);
    check("R1 e_dly", e_dly, 0);
    @(negedge clk); rst = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 18; i++) cycle(VEC[i]);

    // R1: reset mid-run clears accumulated state
    cycle({4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0});
    do_reset();

    // R5 precise: count 3 then E sync gives 7 and count lands on 10
    cycle({4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0});
    cycle({4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0});
    check("R5 precise count", cyc_cnt, 10);
    check("R2 precise e_dly", e_dly, 7);
    // R4 chained: count 10 -> read gap 2 -> write at 12 needs 0
    cycle({4'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
    check("R4 chained wr_dly", wr_dly, 0);
    check("R6 deferred acc", wait_acc, 2);

    // R8: long deferred run saturates the accumulator
    for (int i = 0; i < 60; i++) cycle({4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
    check("R8 saturated acc", wait_acc, 255);
    cycle({4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
    check("R7 saturated release", wait_rel, 255);

    // R9: even steps only from reset
    do_reset();
    for (int i = 0; i < 25; i++) begin
      cycle({4'((i % 4) * 2 + 2), 1'b1, 1'b0, 1'b0, 1'b0, (i % 3 == 2)});
      check("R9 even e_dly", (e_dly % 2 == 0 && e_dly <= 8) ? 1 : 0, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule